// File: doc/BRIEF.md
# Configuration Stream Loader

The loader programs a reconfigurable device from a byte stream. A start command masks the host interrupt enable, pulses the target's reset line for one cycle, waits a programmable number of cycles, and then writes one zero byte to the target's configuration port. It then reads a 16-byte image header from the stream input. The header holds a big-endian payload length in its first four bytes.

The payload bytes pass straight from the stream input to the configuration port under a valid/ready handshake, exactly as many as the header declares. Five zero bytes follow them. The target's error line is watched from the leading zero byte through the last padding byte. A clean load waits a second programmable number of cycles, then raises `done` and unmasks the host interrupt. A load with an error, or a stream that ends early, raises `fail` and leaves the interrupt masked. Both status flags hold until the next start.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader is idle. `busy_o`, `done_o`, `fail_o`, `tgt_rst_o`, `cfg_valid_o` and `img_ready_o` are 0, and `irq_en_o` is 1.
- R2: A start taken while idle drives `tgt_rst_o` high for exactly one cycle. `cfg_valid_o` first rises `rst_wait_i`+2 clock edges after `tgt_rst_o` rises.
- R3: The first byte sent on the configuration port is 0x00. `img_ready_o` stays low until that byte has been accepted.
- R4: The next 16 stream bytes are the header and are never forwarded. Header bytes 0..3 form the payload length, with byte 0 as the most significant.
- R5: Header bytes 4..15 have no effect on the port output or the result. This includes the reserved bytes 12..15.
- R6: Exactly the declared number of payload bytes go to the configuration port, in stream order. Each byte is taken from the stream only when the port accepts it.
- R7: After the payload, exactly five 0x00 bytes are sent.
- R8: If `tgt_err_i` is high in any cycle from the leading byte through the last padding byte, the load ends with `fail_o`=1, `done_o`=0 and `irq_en_o`=0.
- R9: A clean load raises `done_o` on the `rdy_wait_i`+2'th clock edge after the edge that accepts the last padding byte.
- R10: A stream byte marked `img_last_i` that arrives before the last declared payload byte aborts the load with `fail_o`=1. No padding bytes are sent after an abort.
- R11: A declared length of 0 goes straight from the header to the five padding bytes.
- R12: `done_o` and `fail_o` never both read 1. They keep their values while idle until the next start, and a start while busy is ignored.
- R13: `irq_en_o` is 0 while busy. It returns to 1 only when a load ends cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a load (taken only while idle) |
| rst_wait_i | input | WAIT_W | Cycles to wait after the target reset pulse |
| rdy_wait_i | input | WAIT_W | Cycles to wait before reporting success |
| img_valid_i | input | 1 | Stream byte valid |
| img_data_i | input | 8 | Stream byte |
| img_last_i | input | 1 | Marks the final byte of the stream |
| img_ready_o | output | 1 | Stream byte accepted |
| cfg_valid_o | output | 1 | Configuration port byte valid |
| cfg_data_o | output | 8 | Configuration port byte |
| cfg_ready_i | input | 1 | Configuration port accepts the byte |
| tgt_rst_o | output | 1 | Reset pulse to the target |
| tgt_err_i | input | 1 | Error line from the target |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |
| irq_en_o | output | 1 | Host interrupt enable |

## Verification
The bench drives stalls on the port and gaps in the stream. A pass-through that ignores `cfg_ready_i` would then drop or duplicate payload bytes. Two header variants differ only in bytes 4..15, so a loader that reads the wrong length bytes or forwards header bytes shows a mismatched port stream. A zero length, a stream that ends inside the header or payload, and an error pulse in mid-header each go after an off-by-one in the counters: a missing or extra padding byte, a late abort, or an error that is not latched. Both waits are also run at zero, which exposes wait counters that lose or add a cycle.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_RWAIT,
        ST_PRE,
        ST_HDR,
        ST_PAY,
        ST_POST,
        ST_CHK,
        ST_RDYW
    } ld_state_e;
endpackage

// File: rtl/cfg_len_capture.sv
`timescale 1ns/1ps
module cfg_len_capture #(
    parameter int BYTE_W    = 8,
    parameter int LEN_BYTES = 4,
    parameter int IDX_W     = 4,
    localparam int LEN_W    = BYTE_W * LEN_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [LEN_W-1:0]  len_o
);
    logic [LEN_W-1:0] len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (clear_i) begin
            len_d = '0;
        end else if (take_i && (idx_i < IDX_W'(LEN_BYTES))) begin
            len_d = {len_q[LEN_W-BYTE_W-1:0], data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    assign len_o = len_q;
endmodule

// File: rtl/cfg_err_monitor.sv
`timescale 1ns/1ps
module cfg_err_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic arm_i,
    input  logic err_i,
    output logic seen_o
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clear_i)              seen_d = 1'b0;
        else if (arm_i && err_i)  seen_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign seen_o = seen_q;
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int WAIT_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int HDR_BYTES = 16,
    parameter int LEN_BYTES = 4,
    parameter int PAD_BYTES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] rst_wait_i,
    input  logic [WAIT_W-1:0] rdy_wait_i,
    input  logic              img_valid_i,
    input  logic [BYTE_W-1:0] img_data_i,
    input  logic              img_last_i,
    output logic              img_ready_o,
    output logic              cfg_valid_o,
    output logic [BYTE_W-1:0] cfg_data_o,
    input  logic              cfg_ready_i,
    output logic              tgt_rst_o,
    input  logic              tgt_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              irq_en_o
);
    localparam int LEN_W = BYTE_W * LEN_BYTES;
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam logic [WAIT_W-1:0] HDR_LAST = WAIT_W'(HDR_BYTES - 1);
    localparam logic [WAIT_W-1:0] PAD_LAST = WAIT_W'(PAD_BYTES - 1);

    typedef struct packed {
        ld_state_e         st;
        logic [WAIT_W-1:0] cnt;
        logic [LEN_W-1:0]  rem;
        logic              done;
        logic              fail;
        logic              irq_en;
    } regs_t;

    regs_t r_d, r_q;

    logic             len_clr, hdr_take, err_clr, err_arm, err_seen;
    logic [LEN_W-1:0] hdr_len;

    cfg_len_capture #(
        .BYTE_W   (BYTE_W),
        .LEN_BYTES(LEN_BYTES),
        .IDX_W    (IDX_W)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(len_clr),
        .take_i (hdr_take),
        .idx_i  (r_q.cnt[IDX_W-1:0]),
        .data_i (img_data_i),
        .len_o  (hdr_len)
    );

    assign err_arm = (r_q.st == ST_PRE) || (r_q.st == ST_HDR) ||
                     (r_q.st == ST_PAY) || (r_q.st == ST_POST);

    cfg_err_monitor u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(err_clr),
        .arm_i  (err_arm),
        .err_i  (tgt_err_i),
        .seen_o (err_seen)
    );

    always_comb begin
        r_d         = r_q;
        img_ready_o = 1'b0;
        cfg_valid_o = 1'b0;
        cfg_data_o  = '0;
        tgt_rst_o   = 1'b0;
        len_clr     = 1'b0;
        hdr_take    = 1'b0;
        err_clr     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_RST;
                    r_d.done   = 1'b0;
                    r_d.fail   = 1'b0;
                    r_d.irq_en = 1'b0;
                    len_clr    = 1'b1;
                    err_clr    = 1'b1;
                end
            end
            ST_RST: begin
                tgt_rst_o = 1'b1;
                r_d.cnt   = rst_wait_i;
                r_d.st    = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (r_q.cnt == '0) r_d.st  = ST_PRE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_PRE: begin
                cfg_valid_o = 1'b1;
                if (cfg_ready_i) begin
                    r_d.st  = ST_HDR;
                    r_d.cnt = '0;
                end
            end
            ST_HDR: begin
                img_ready_o = 1'b1;
                if (img_valid_i) begin
                    hdr_take = 1'b1;
                    if (r_q.cnt == HDR_LAST) begin
                        r_d.rem = hdr_len;
                        r_d.cnt = '0;
                        if (hdr_len == '0) begin
                            r_d.st = ST_POST;
                        end else if (img_last_i) begin
                            r_d.st   = ST_IDLE;
                            r_d.fail = 1'b1;
                        end else begin
                            r_d.st = ST_PAY;
                        end
                    end else if (img_last_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.fail = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                cfg_valid_o = img_valid_i;
                cfg_data_o  = img_data_i;
                img_ready_o = cfg_ready_i;
                if (img_valid_i && cfg_ready_i) begin
                    r_d.rem = r_q.rem - 1'b1;
                    if (r_q.rem == LEN_W'(1)) begin
                        r_d.st  = ST_POST;
                        r_d.cnt = '0;
                    end else if (img_last_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.fail = 1'b1;
                    end
                end
            end
            ST_POST: begin
                cfg_valid_o = 1'b1;
                if (cfg_ready_i) begin
                    if (r_q.cnt == PAD_LAST) r_d.st  = ST_CHK;
                    else                     r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CHK: begin
                if (err_seen) begin
                    r_d.st   = ST_IDLE;
                    r_d.fail = 1'b1;
                end else begin
                    r_d.cnt = rdy_wait_i;
                    r_d.st  = ST_RDYW;
                end
            end
            ST_RDYW: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.irq_en = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.rem    <= '0;
            r_q.done   <= 1'b0;
            r_q.fail   <= 1'b0;
            r_q.irq_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign fail_o   = r_q.fail;
    assign irq_en_o = r_q.irq_en;
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic fail_o,
    input logic irq_en_o,
    input logic tgt_rst_o,
    input logic img_ready_o,
    input logic cfg_valid_o
);
    p_irq_masked_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !irq_en_o);

    p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst_o |=> !tgt_rst_o);

    p_rst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst_o |-> (!img_ready_o && !cfg_valid_o));

    p_status_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(done_o) && $stable(fail_o)));

    p_fail_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !irq_en_o);

    p_done_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> irq_en_o);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .irq_en_o   (irq_en_o),
    .tgt_rst_o  (tgt_rst_o),
    .img_ready_o(img_ready_o),
    .cfg_valid_o(cfg_valid_o)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;
    localparam int WAIT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [WAIT_W-1:0] rst_wait = '0;
    logic [WAIT_W-1:0] rdy_wait = '0;
    logic              img_valid = 1'b0;
    logic [7:0]        img_data = '0;
    logic              img_last = 1'b0;
    logic              img_ready;
    logic              cfg_valid;
    logic [7:0]        cfg_data;
    logic              cfg_ready = 1'b0;
    logic              tgt_rst;
    logic              tgt_err = 1'b0;
    logic              busy, done, fail, irq_en;

    always #2.5 clk = ~clk;

    cfg_loader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .rst_wait_i (rst_wait),
        .rdy_wait_i (rdy_wait),
        .img_valid_i(img_valid),
        .img_data_i (img_data),
        .img_last_i (img_last),
        .img_ready_o(img_ready),
        .cfg_valid_o(cfg_valid),
        .cfg_data_o (cfg_data),
        .cfg_ready_i(cfg_ready),
        .tgt_rst_o  (tgt_rst),
        .tgt_err_i  (tgt_err),
        .busy_o     (busy),
        .done_o     (done),
        .fail_o     (fail),
        .irq_en_o   (irq_en)
    );

    int checks = 0;
    int errors = 0;
    byte unsigned src_d[$];
    bit           src_l[$];
    byte unsigned exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Build the stream and the expected port bytes (leading zero + payload)
    task automatic build(input int unsigned lenf, input int npay,
                         input byte unsigned rsv, input byte unsigned mid,
                         input int seed, input int hdr_cut);
        src_d.delete(); src_l.delete(); exp_q.delete();
        exp_q.push_back(8'h00);
        for (int i = 0; i < 16; i++) begin
            byte unsigned b;
            if (i < 4)       b = byte'(lenf >> (8 * (3 - i)));
            else if (i < 12) b = byte'(mid + i);
            else             b = byte'(rsv + i);
            src_d.push_back(b);
            if (hdr_cut == i) begin
                src_l.push_back(1'b1);
                return;
            end
            src_l.push_back(1'b0);
        end
        if (npay == 0) src_l[15] = 1'b1;
        for (int i = 0; i < npay; i++) begin
            byte unsigned b;
            b = byte'((seed + i * 37) & 255);
            src_d.push_back(b);
            src_l.push_back(i == npay - 1);
            exp_q.push_back(b);
        end
    endtask

    task automatic add_pads();
        for (int i = 0; i < 5; i++) exp_q.push_back(8'h00);
    endtask

    task automatic do_load(input int rw, input int yw, input int rmode, input int vmode,
                           input int err_at, input int restart_at, input bit exp_fail,
                           input string req);
        int rst_c = -1, rst_w = 0, ov_c = -1, hs_c = -1, end_c = -1;
        int irq_bad = 0, mism = 0, lead_bad = 0;
        bit lead_done = 0;
        rst_wait = WAIT_W'(rw);
        rdy_wait = WAIT_W'(yw);
        @(negedge clk);
        start = 1'b1; img_valid = 1'b0; cfg_ready = 1'b0; tgt_err = 1'b0;
        for (int c = 1; c < 3000; c++) begin
            @(negedge clk);
            start     = (c == restart_at);
            img_valid = (src_d.size() > 0) && (vmode == 0 || (c % 3) != 0);
            img_data  = img_valid ? src_d[0] : 8'h00;
            img_last  = img_valid ? src_l[0] : 1'b0;
            cfg_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'((c % 2)) : ((c % 3) != 1);
            tgt_err   = (c == err_at);
            #1;
            if (tgt_rst) begin
                if (rst_c < 0) rst_c = c;
                rst_w++;
            end
            if (cfg_valid && ov_c < 0) ov_c = c;
            if (busy && irq_en) irq_bad++;
            if (img_ready && !lead_done) lead_bad++;
            if (cfg_valid && cfg_ready) begin
                if (exp_q.size() == 0) begin
                    mism++;
                    $display("FAIL %s extra port byte actual=%0d expected=none", req, cfg_data);
                end else begin
                    byte unsigned e;
                    e = exp_q.pop_front();
                    if (cfg_data != e) begin
                        mism++;
                        $display("FAIL %s port byte actual=%0d expected=%0d", req, cfg_data, e);
                    end
                end
                lead_done = 1'b1;
                hs_c = c;
            end
            if (img_valid && img_ready) begin
                void'(src_d.pop_front());
                void'(src_l.pop_front());
            end
            if (!busy) begin
                end_c = c;
                break;
            end
        end
        start = 1'b0; img_valid = 1'b0; img_last = 1'b0; tgt_err = 1'b0;
        chk(end_c > 0, req, "load ends", end_c, 1);
        chk(rst_w == 1, "R2", "reset pulse width", rst_w, 1);
        chk(ov_c - rst_c == rw + 2, "R2", "reset-to-first-byte edges", ov_c - rst_c, rw + 2);
        chk(lead_bad == 0, "R3", "stream taken before leading byte", lead_bad, 0);
        chk(mism == 0, req, "port byte mismatches", mism, 0);
        chk(exp_q.size() == 0, req, "port bytes missing", exp_q.size(), 0);
        chk(fail == exp_fail, req, "fail flag", fail, exp_fail);
        chk(done == !exp_fail, req, "done flag", done, !exp_fail);
        chk(irq_en == !exp_fail, "R13", "irq enable after load", irq_en, !exp_fail);
        chk(irq_bad == 0, "R13", "irq enabled while busy", irq_bad, 0);
        if (!exp_fail)
            chk(end_c - hs_c == yw + 3, "R9", "ready wait timing", end_c - hs_c, yw + 3);
    endtask

    task automatic hold_check(input string req);
        bit d0, f0;
        d0 = done; f0 = fail;
        repeat (8) @(negedge clk);
        #1;
        chk(done == d0 && fail == f0 && !busy, req, "status held while idle",
            {done, fail}, {d0, f0});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(!busy && !done && !fail, "R1", "idle status after reset", {busy, done, fail}, 0);
        chk(!tgt_rst && !cfg_valid && !img_ready, "R1", "outputs quiet after reset",
            {tgt_rst, cfg_valid, img_ready}, 0);
        chk(irq_en == 1'b1, "R13", "irq enabled after reset", irq_en, 1);

        // R4 R6 R7 basic load
        build(32'd8, 8, 8'h11, 8'h20, 5, -1); add_pads();
        do_load(3, 4, 0, 0, -1, -1, 1'b0, "R4_R6_R7");
        hold_check("R12");

        // R5 different bytes 4..15, stalls and gaps, same expected stream
        build(32'd8, 8, 8'hE7, 8'h90, 5, -1); add_pads();
        do_load(3, 4, 1, 1, -1, -1, 1'b0, "R5");

        // R6 longer payload with a length crossing the byte boundary
        build(32'd300, 300, 8'h00, 8'h00, 77, -1); add_pads();
        do_load(1, 2, 2, 1, -1, -1, 1'b0, "R6");

        // R11 zero length goes straight to padding
        build(32'd0, 0, 8'h33, 8'h44, 0, -1); add_pads();
        do_load(2, 1, 0, 0, -1, -1, 1'b0, "R11");

        // R8 error pulse during header
        build(32'd12, 12, 8'h01, 8'h02, 9, -1); add_pads();
        do_load(2, 3, 0, 0, 9, -1, 1'b1, "R8");
        hold_check("R12");

        // R10 stream ends inside the payload
        build(32'd20, 6, 8'h05, 8'h06, 3, -1);
        do_load(1, 1, 1, 0, -1, -1, 1'b1, "R10");

        // R10 stream ends inside the header
        build(32'd20, 0, 8'h05, 8'h06, 3, 7);
        do_load(1, 1, 0, 1, -1, -1, 1'b1, "R10");

        // R12 start while busy is ignored; R2 R9 zero waits
        build(32'd5, 5, 8'h55, 8'h66, 200, -1); add_pads();
        do_load(0, 0, 0, 0, -1, 6, 1'b0, "R12");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule